// File: doc/BRIEF.md
# Subtract-and-Branch Single-Instruction Core

This block is a small processor core with exactly one instruction and no opcode field. Each instruction occupies three consecutive memory words. Each of the three words is an absolute word address: a source cell, a destination cell and a jump target. The core subtracts the source cell's value from the destination cell's value. It stores the two's-complement difference back into the destination cell. It then either jumps to the target or moves on to the next three-word group, depending on the sign of the difference. Code and data share one word-addressed memory. Programs may therefore modify their own operands.

The core makes at most one access per cycle to a synchronous single-port memory that returns read data one cycle after the address. One instruction always takes seven cycles: three operand fetches, two data reads, one write-back and one program-counter update. A taken branch whose target has every address bit set stops the core. Halt then stays high and the program counter freezes until reset. The `ZERO_TAKEN` parameter decides whether a zero difference counts as a taken branch.

Top module: `sbr_core`

## Requirements
- R1: While `rst` is high on a rising edge, the next cycle shows `pc` = 0, `halt` = 0 and `mem_we` = 0, whatever state the core was in before.
- R2: An instruction at address P presents, on consecutive cycles, the addresses P, P+1, P+2 (operand words a, b, c), then a, then b, then b again for the write; address arithmetic wraps modulo 2^ADDR_W and an operand word's low ADDR_W bits form the address.
- R3: The write-back stores mem[b] − mem[a] into mem[b], truncated to DATA_W bits (two's-complement wrap), using values read before the write.
- R4: With `ZERO_TAKEN` = 1, a difference that is zero or negative (sign bit set) makes the next instruction start at c.
- R5: With `ZERO_TAKEN` = 0, only a negative difference is taken; a zero difference falls through.
- R6: A branch that is not taken makes the next instruction start at P+3.
- R7: A taken branch whose target c has all ADDR_W low bits set raises `halt`; from then on `halt` stays high, `pc` keeps the address of the halting instruction, and no memory write occurs.
- R8: Every instruction takes exactly seven cycles and performs exactly one write, and that write is held for one cycle only; a program of N instructions raises `halt` 7·N cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Word address presented to memory this cycle |
| mem_we | output | 1 | Write enable for the write-back cycle |
| mem_wdata | output | DATA_W | Difference written to the destination cell |
| mem_rdata | input | DATA_W | Read data, valid the cycle after its address |
| halt | output | 1 | High once the core has stopped |
| pc | output | ADDR_W | Address of the current instruction |

## Verification
The hardest conditions to reach from the ports are differences that land exactly on zero or on the two's-complement wrap boundary. The two parameter settings part ways only in those cases. The bench runs a zero-taken core and a strict core side by side on the same memory image, so each program checks both modes at once. Random programs draw their data cells from zero, one, minus one and the two extreme values. They also jump forward at random, so that taken and fall-through paths both occur. Every program ends in a halting instruction, so each run ends with a known instruction count.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    // Words per instruction: source, destination, target.
    localparam int unsigned OPERAND_COUNT = 3;

    typedef enum logic [2:0] {
        ST_FETCH_A   = 3'd0,
        ST_FETCH_B   = 3'd1,
        ST_FETCH_C   = 3'd2,
        ST_READ_A    = 3'd3,
        ST_READ_B    = 3'd4,
        ST_WRITE_B   = 3'd5,
        ST_UPDATE_PC = 3'd6,
        ST_HALTED    = 3'd7
    } step_e;

    // Straight-line order of the instruction steps; the update step is resolved by the sequencer.
    function automatic step_e step_after(step_e s);
        case (s)
            ST_FETCH_A: return ST_FETCH_B;
            ST_FETCH_B: return ST_FETCH_C;
            ST_FETCH_C: return ST_READ_A;
            ST_READ_A:  return ST_READ_B;
            ST_READ_B:  return ST_WRITE_B;
            ST_WRITE_B: return ST_UPDATE_PC;
            default:    return s;
        endcase
    endfunction

endpackage

// File: rtl/sbr_seq.sv
module sbr_seq
    import sbr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stop_req,
    output step_e step
);

    always_ff @(posedge clk) begin
        if (rst) begin
            step <= ST_FETCH_A;
        end else if (step == ST_UPDATE_PC) begin
            step <= stop_req ? ST_HALTED : ST_FETCH_A;
        end else begin
            step <= step_after(step);
        end
    end

endmodule

// File: rtl/sbr_operands.sv
module sbr_operands
    import sbr_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  step_e             step,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] diff,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [ADDR_W-1:0] target,
    output logic [DATA_W-1:0] src_val,
    output logic [DATA_W-1:0] result
);

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] tgt;
    } opset_t;

    opset_t ops_q;

    // Each capture takes the data that the previous step's address returned.
    always_ff @(posedge clk) begin
        if (rst) begin
            ops_q   <= '0;
            src_val <= '0;
            result  <= '0;
        end else begin
            case (step)
                ST_FETCH_B:  ops_q.src <= rdata[ADDR_W-1:0];
                ST_FETCH_C:  ops_q.dst <= rdata[ADDR_W-1:0];
                ST_READ_A:   ops_q.tgt <= rdata[ADDR_W-1:0];
                ST_READ_B:   src_val   <= rdata;
                ST_WRITE_B:  result    <= diff;
                default:     ;
            endcase
        end
    end

    assign src_addr = ops_q.src;
    assign dst_addr = ops_q.dst;
    assign target   = ops_q.tgt;

endmodule

// File: rtl/sbr_alu.sv
module sbr_alu #(
    parameter int unsigned DATA_W     = 16,
    parameter bit          ZERO_TAKEN = 1'b1
) (
    input  logic [DATA_W-1:0] minuend,
    input  logic [DATA_W-1:0] subtrahend,
    input  logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] diff,
    output logic              taken
);

    assign diff = minuend - subtrahend;

    generate
        if (ZERO_TAKEN) begin : g_le_zero
            assign taken = result[DATA_W-1] | (result == '0);
        end else begin : g_lt_zero
            assign taken = result[DATA_W-1];
        end
    endgenerate

endmodule

// File: rtl/sbr_pc.sv
module sbr_pc
    import sbr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  step_e             step,
    input  logic              taken,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc,
    output logic              stop_req
);

    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(OPERAND_COUNT);

    assign stop_req = (step == ST_UPDATE_PC) && taken && (&target);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (step == ST_UPDATE_PC && !stop_req) begin
            pc <= taken ? target : pc + STRIDE;
        end
    end

endmodule

// File: rtl/sbr_core.sv
module sbr_core
    import sbr_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned ADDR_W     = 8,
    parameter bit          ZERO_TAKEN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halt,
    output logic [ADDR_W-1:0] pc
);

    step_e             step;
    logic              stop_req;
    logic              taken;
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;
    logic [ADDR_W-1:0] target;
    logic [DATA_W-1:0] src_val;
    logic [DATA_W-1:0] result;
    logic [DATA_W-1:0] diff;

    sbr_seq seq_i (
        .clk      (clk),
        .rst      (rst),
        .stop_req (stop_req),
        .step     (step)
    );

    sbr_operands #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ops_i (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .rdata    (mem_rdata),
        .diff     (diff),
        .src_addr (src_addr),
        .dst_addr (dst_addr),
        .target   (target),
        .src_val  (src_val),
        .result   (result)
    );

    // In the write step the read data is the destination value read one cycle earlier.
    sbr_alu #(.DATA_W(DATA_W), .ZERO_TAKEN(ZERO_TAKEN)) alu_i (
        .minuend    (mem_rdata),
        .subtrahend (src_val),
        .result     (result),
        .diff       (diff),
        .taken      (taken)
    );

    sbr_pc #(.ADDR_W(ADDR_W)) pc_i (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .taken    (taken),
        .target   (target),
        .pc       (pc),
        .stop_req (stop_req)
    );

    always_comb begin
        case (step)
            ST_FETCH_A:               mem_addr = pc;
            ST_FETCH_B:               mem_addr = pc + ADDR_W'(1);
            ST_FETCH_C:               mem_addr = pc + ADDR_W'(2);
            ST_READ_A:                mem_addr = src_addr;
            ST_READ_B, ST_WRITE_B:    mem_addr = dst_addr;
            default:                  mem_addr = pc;
        endcase
    end

    assign mem_we    = (step == ST_WRITE_B);
    assign mem_wdata = diff;
    assign halt      = (step == ST_HALTED);

endmodule

// File: rtl/sbr_core_chk.sv
module sbr_core_chk #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              halt,
    input logic [ADDR_W-1:0] pc
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pc == '0 && !halt && !mem_we));

    // R7
    halt_holds_chk: assert property (@(posedge clk) disable iff (rst)
        halt |=> (halt && $stable(pc)));

    // R7
    halt_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        halt |-> !mem_we);

    // R8
    single_write_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R2
    write_same_cell_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr == $past(mem_addr)));

endmodule

bind sbr_core sbr_core_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .halt     (halt),
    .pc       (pc)
);

// File: tb/sbr_core_tb_top.sv
`timescale 1ns/1ps

module sbr_tb_mem #(
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [2**AW];

    always_ff @(posedge clk) begin
        if (ld_en) begin
            cells[ld_addr] <= ld_data;
        end else begin
            if (we) cells[addr] <= wdata;
            rdata <= cells[addr];
        end
    end
endmodule

module sbr_core_tb_top;
    localparam int DW    = 16;
    localparam int AW    = 8;
    localparam int DEPTH = 2**AW;
    localparam logic [DW-1:0] STOP = '1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          ld_en   = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;

    logic [AW-1:0] addr_d, addr_n, pc_d, pc_n;
    logic          we_d, we_n, halt_d, halt_n;
    logic [DW-1:0] wd_d, wd_n, rd_d, rd_n;

    sbr_tb_mem #(.DW(DW), .AW(AW)) md (.clk(clk), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .addr(addr_d), .we(we_d), .wdata(wd_d), .rdata(rd_d));
    sbr_tb_mem #(.DW(DW), .AW(AW)) mn (.clk(clk), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .addr(addr_n), .we(we_n), .wdata(wd_n), .rdata(rd_n));

    sbr_core #(.DATA_W(DW), .ADDR_W(AW), .ZERO_TAKEN(1'b1)) dut_i (
        .clk(clk), .rst(rst), .mem_addr(addr_d), .mem_we(we_d), .mem_wdata(wd_d),
        .mem_rdata(rd_d), .halt(halt_d), .pc(pc_d));
    sbr_core #(.DATA_W(DW), .ADDR_W(AW), .ZERO_TAKEN(1'b0)) dut_n (
        .clk(clk), .rst(rst), .mem_addr(addr_n), .mem_we(we_n), .mem_wdata(wd_n),
        .mem_rdata(rd_n), .halt(halt_n), .pc(pc_n));

    logic [DW-1:0] img [DEPTH];
    logic [DW-1:0] wk  [DEPTH];

    int n_chk = 0;
    int n_err = 0;
    int hcyc_d, hcyc_n, wr_d, wr_n, wrh_d, wrh_n;
    logic [AW-1:0] pch_d, pch_n;
    logic [AW-1:0] tr_addr [8];
    logic          tr_we   [8];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin
        #(4 * 100000);
        n_err++;
        $display("FAIL R8 watchdog expired: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Loads img into both memories under reset, then checks the reset state.
    task automatic load_image();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = AW'(i); ld_data = img[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
        chk(pc_d == '0 && !halt_d && !we_d, "R1", "reset state zero-taken core", pc_d, 0);
        chk(pc_n == '0 && !halt_n && !we_n, "R1", "reset state strict core", pc_n, 0);
    endtask

    task automatic run_both();
        int cyc;
        hcyc_d = -1; hcyc_n = -1; wr_d = 0; wr_n = 0; cyc = 0;
        rst = 1'b0;
        while (cyc < 6000) begin
            if (we_d) wr_d++;
            if (we_n) wr_n++;
            if (cyc < 8) begin tr_addr[cyc] = addr_d; tr_we[cyc] = we_d; end
            if (halt_d && hcyc_d < 0) begin hcyc_d = cyc; pch_d = pc_d; wrh_d = wr_d; end
            if (halt_n && hcyc_n < 0) begin hcyc_n = cyc; pch_n = pc_n; wrh_n = wr_n; end
            if (hcyc_d >= 0 && hcyc_n >= 0 &&
                cyc >= ((hcyc_d > hcyc_n) ? hcyc_d : hcyc_n) + 10) break;
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic model(input bit zt, output int n, output logic [AW-1:0] fpc);
        logic [AW-1:0] p, p1, p2, a, b;
        logic [DW-1:0] c, r;
        bit tk, done;
        for (int i = 0; i < DEPTH; i++) wk[i] = img[i];
        p = '0; n = 0; done = 1'b0;
        for (int s = 0; s < 2000 && !done; s++) begin
            p1 = p + AW'(1); p2 = p + AW'(2);
            a = wk[p][AW-1:0]; b = wk[p1][AW-1:0]; c = wk[p2];
            r = wk[b] - wk[a];
            wk[b] = r;
            n++;
            tk = zt ? (r[DW-1] || r == '0) : r[DW-1];
            if (tk && (&c[AW-1:0])) done = 1'b1;
            else if (tk) p = c[AW-1:0];
            else p = p + AW'(3);
        end
        fpc = p;
    endtask

    task automatic evaluate(input string tag);
        int n, bad;
        logic [AW-1:0] fp;
        model(1'b1, n, fp);
        bad = -1;
        for (int i = 0; i < DEPTH; i++) if (md.cells[i] !== wk[i] && bad < 0) bad = i;
        chk(bad < 0, "R3 R4", {tag, " zero-taken memory"},
            (bad < 0) ? 0 : md.cells[bad], (bad < 0) ? 0 : wk[bad]);
        chk(pc_d === fp, "R4 R6", {tag, " zero-taken final pc"}, pc_d, fp);
        chk(hcyc_d == 7 * n, "R8", {tag, " zero-taken halt cycle"}, hcyc_d, 7 * n);
        chk(wr_d == n, "R8", {tag, " zero-taken write count"}, wr_d, n);
        chk(pc_d === pch_d && wr_d == wrh_d, "R7", {tag, " zero-taken frozen after halt"}, pc_d, pch_d);
        model(1'b0, n, fp);
        bad = -1;
        for (int i = 0; i < DEPTH; i++) if (mn.cells[i] !== wk[i] && bad < 0) bad = i;
        chk(bad < 0, "R3 R5", {tag, " strict memory"},
            (bad < 0) ? 0 : mn.cells[bad], (bad < 0) ? 0 : wk[bad]);
        chk(pc_n === fp, "R5 R6", {tag, " strict final pc"}, pc_n, fp);
        chk(hcyc_n == 7 * n, "R8", {tag, " strict halt cycle"}, hcyc_n, 7 * n);
        chk(wr_n == n, "R8", {tag, " strict write count"}, wr_n, n);
        chk(pc_n === pch_n && wr_n == wrh_n, "R7", {tag, " strict frozen after halt"}, pc_n, pch_n);
    endtask

    task automatic clear_image();
        for (int i = 0; i < DEPTH; i++) img[i] = '0;
        img[220] = 16'd1;
    endtask

    function automatic logic [DW-1:0] pick_value();
        case ($urandom % 6)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'hFFFF;
            3: return 16'h7FFF;
            4: return 16'h8000;
            default: return DW'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd2718));

        // Directed: add X into Y through a scratch cell, then halt.
        for (int t = 0; t < 3; t++) begin
            logic [DW-1:0] x, y;
            x = (t == 0) ? 16'd1234 : DW'($urandom);
            y = (t == 0) ? 16'hFFB3 : DW'($urandom);
            clear_image();
            img[200] = x; img[201] = y; img[202] = '0;
            img[0] = 16'd200; img[1]  = 16'd202; img[2]  = 16'd3;
            img[3] = 16'd202; img[4]  = 16'd201; img[5]  = 16'd6;
            img[6] = 16'd202; img[7]  = 16'd202; img[8]  = 16'd9;
            img[9] = 16'd220; img[10] = 16'd221; img[11] = STOP;
            load_image();
            run_both();
            chk(md.cells[201] == x + y, "R3", "addition result", md.cells[201], x + y);
            chk(md.cells[202] == '0, "R3", "scratch cell cleared", md.cells[202], 0);
            chk(mn.cells[201] == x + y, "R3", "addition result strict", mn.cells[201], x + y);
            if (t == 0) begin
                chk(tr_addr[0] == 8'd0 && tr_addr[1] == 8'd1 && tr_addr[2] == 8'd2,
                    "R2", "operand fetch addresses", tr_addr[2], 2);
                chk(tr_addr[3] == 8'd200 && tr_addr[4] == 8'd202 && tr_addr[5] == 8'd202,
                    "R2", "data read and write addresses", tr_addr[5], 202);
                chk(tr_we[5] && !tr_we[4] && !tr_we[6], "R8", "write only in sixth cycle",
                    tr_we[5], 1);
            end
            evaluate("addition");
        end

        // Directed: zero difference splits the two modes.
        clear_image();
        img[200] = 16'd5;
        img[0] = 16'd200; img[1] = 16'd200; img[2] = 16'd6;
        img[3] = 16'd220; img[4] = 16'd221; img[5] = STOP;
        img[6] = 16'd220; img[7] = 16'd222; img[8] = STOP;
        load_image();
        run_both();
        chk(pc_d == 8'd6, "R4", "zero result taken halts at target path", pc_d, 6);
        chk(pc_n == 8'd3, "R5", "zero result falls through in strict mode", pc_n, 3);
        chk(mn.cells[221] == 16'hFFFF && mn.cells[222] == '0, "R6", "strict path ran next group",
            mn.cells[221], 16'hFFFF);
        evaluate("zero-boundary");

        // Directed: wrap from most negative minus one gives a positive difference.
        clear_image();
        img[200] = 16'h8000; img[201] = 16'd1;
        img[0] = 16'd201; img[1] = 16'd200; img[2] = 16'd9;
        img[3] = 16'd220; img[4] = 16'd221; img[5] = STOP;
        img[9] = 16'd220; img[10] = 16'd222; img[11] = STOP;
        load_image();
        run_both();
        chk(md.cells[200] == 16'h7FFF, "R3", "wrapped difference", md.cells[200], 16'h7FFF);
        chk(pc_d == 8'd3, "R6", "positive wrap not taken", pc_d, 3);
        evaluate("wrap");

        // Random programs with forward jumps ending in a halting instruction.
        for (int t = 0; t < 20; t++) begin
            int k;
            clear_image();
            k = 2 + int'($urandom % 7);
            for (int d = 0; d < 16; d++) img[200 + d] = pick_value();
            for (int i = 0; i < k - 1; i++) begin
                int j;
                j = i + 1 + int'($urandom % (k - 1 - i));
                img[3 * i]     = DW'(200 + ($urandom % 16));
                img[3 * i + 1] = DW'(200 + ($urandom % 16));
                img[3 * i + 2] = DW'(3 * j);
            end
            img[3 * (k - 1)]     = 16'd220;
            img[3 * (k - 1) + 1] = 16'd221;
            img[3 * (k - 1) + 2] = STOP;
            load_image();
            run_both();
            evaluate("random");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule